// File: doc/BRIEF.md
# Bridge PWM Output Steering

This block sits behind a PWM generator and turns one base PWM waveform into four active-high drive signals for the switches of a power bridge, named A, B, C and D. In half-bridge mode A carries the PWM and B its complement. Each switch-on edge is held back by a programmable dead time so that one switch can turn off before its partner turns on. Switch-off edges pass through at once.

In full-bridge mode one leg is held on and the diagonal switch carries the PWM. A direction input picks which diagonal is used. The direction input may change at any time. The change is applied near the end of the running period. The generator supplies a countdown of input clocks left in the current period. When the new direction is applied, the held-on outputs move a set number of clocks before the period ends, and both modulated outputs are held off until the next period starts. This prevents a diagonal pair from conducting while the legs swap.

The period and duty generation is not part of this block, and neither are polarity options or fault shutdown. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `bridge_steer`

## Requirements
- R1: When mode_full is 0 (half-bridge), out_a follows pwm_in, out_b follows its complement, and out_c and out_d are 0.
- R2: In half-bridge mode, a 0-to-1 change of out_a or out_b happens 4*dead_cnt clocks after its request goes active (pwm_in high for A, low for B). With dead_cnt = 0 there is no delay.
- R3: In half-bridge mode, a 1-to-0 change of out_a or out_b follows the request with no delay. A request that drops before its delay expires leaves the output at 0.
- R4: When mode_full is 1 and the applied direction is forward (dir_rev = 0), the outputs are out_a = 1, out_d = pwm_in, out_b = 0 and out_c = 0. In reverse (dir_rev = 1) they are out_c = 1, out_b = pwm_in, out_a = 0 and out_d = 0.
- R5: dir_rev is registered on every clock into a pending value. A new direction in full-bridge mode does not change the outputs before the early-switch point of the current period.
- R6: end_cnt gives the clocks left in the period, with 0 on the last clock. The early-switch point is the clock where end_cnt equals the lead: 1 for psc_sel = 00, 4 for 01, and 16 for 10 or 11. If the pending direction differs from the applied one there, the new direction holds from the next clock on. That makes exactly lead clocks before the new period.
- R7: From the early-switch point until the first clock of the next period, out_b and out_d are 0 whatever pwm_in does.
- R8: A direction change that is undone before the early-switch point has no effect. There is no blanking and no output change.
- R9: After reset the applied direction is forward and the deadband counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_full | input | 1 | 1 = full-bridge, 0 = half-bridge |
| dir_rev | input | 1 | Full-bridge direction, 1 = reverse |
| dead_cnt | input | 8 | Dead time in units of 4 clocks |
| psc_sel | input | 2 | Selects the early-switch lead (1, 4 or 16 clocks) |
| pwm_in | input | 1 | Base PWM waveform |
| end_cnt | input | 8 | Clocks left in the current period, 0 on the last clock |
| out_a | output | 1 | Bridge drive A, active-high |
| out_b | output | 1 | Bridge drive B, active-high |
| out_c | output | 1 | Bridge drive C, active-high |
| out_d | output | 1 | Bridge drive D, active-high |

## Verification
The hardest case to reach is the window between the early-switch point and the period end. The new direction and the blanking of the modulated outputs are visible only there, and the window's length depends on psc_sel. The bench generates the period countdown itself. It changes direction at the start of a period, then checks every clock of that period and the next against a computed lead, for every psc_sel code. It also runs a change that is undone a few clocks later, to confirm that only the value at the early-switch point counts.

// File: rtl/bs_pkg.sv
package bs_pkg;
  typedef enum logic {DIR_FWD = 1'b0, DIR_REV = 1'b1} dir_e;

  // lead (clocks before period end) for each prescaler select code
  function automatic int unsigned lead_clks(input logic [1:0] sel);
    case (sel)
      2'b00:   lead_clks = 1;
      2'b01:   lead_clks = 4;
      default: lead_clks = 16;
    endcase
  endfunction
endpackage

// File: rtl/bs_deadband.sv
module bs_deadband #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] target,
  output logic          act
);
  logic [CW-1:0] cnt;

  // counts clocks with req held; saturates at target
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!req) begin
      cnt <= '0;
    end else if (cnt < target) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign act = req && (cnt >= target);
endmodule

// File: rtl/bs_dir_ctrl.sv
module bs_dir_ctrl
  import bs_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_en,
  input  logic          dir_req,
  input  logic [1:0]    psc_sel,
  input  logic [EW-1:0] end_cnt,
  output dir_e          dir_app,
  output logic          blank
);
  dir_e          dir_pend;
  logic [EW-1:0] lead_val;
  logic          at_lead;

  assign lead_val = EW'(lead_clks(psc_sel));
  assign at_lead  = (end_cnt == lead_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_pend <= DIR_FWD;
      dir_app  <= DIR_FWD;
      blank    <= 1'b0;
    end else begin
      dir_pend <= dir_e'(dir_req);
      if (!full_en) begin
        dir_app <= dir_pend;
        blank   <= 1'b0;
      end else if (at_lead && (dir_pend != dir_app)) begin
        dir_app <= dir_pend;
        blank   <= 1'b1;
      end else if (end_cnt == '0) begin
        blank   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bridge_steer.sv
module bridge_steer
  import bs_pkg::*;
#(
  parameter int DW = 8,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_full,
  input  logic          dir_rev,
  input  logic [DW-1:0] dead_cnt,
  input  logic [1:0]    psc_sel,
  input  logic          pwm_in,
  input  logic [EW-1:0] end_cnt,
  output logic          out_a,
  output logic          out_b,
  output logic          out_c,
  output logic          out_d
);
  localparam int CW    = DW + 2;
  localparam int LANES = 2;

  logic [CW-1:0]    db_target;
  logic [LANES-1:0] db_req;
  logic [LANES-1:0] db_act;
  dir_e             dir_app;
  logic             blank;
  logic             mod_on;

  assign db_target = {dead_cnt, 2'b00};
  assign db_req[0] = !mode_full && pwm_in;
  assign db_req[1] = !mode_full && !pwm_in;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      bs_deadband #(.CW(CW)) u_db (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (db_req[g]),
        .target (db_target),
        .act    (db_act[g])
      );
    end
  endgenerate

  bs_dir_ctrl #(.EW(EW)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .full_en (mode_full),
    .dir_req (dir_rev),
    .psc_sel (psc_sel),
    .end_cnt (end_cnt),
    .dir_app (dir_app),
    .blank   (blank)
  );

  assign mod_on = pwm_in && !blank;

  always_comb begin
    if (!mode_full) begin
      out_a = db_act[0];
      out_b = db_act[1];
      out_c = 1'b0;
      out_d = 1'b0;
    end else if (dir_app == DIR_FWD) begin
      out_a = 1'b1;
      out_b = 1'b0;
      out_c = 1'b0;
      out_d = mod_on;
    end else begin
      out_a = 1'b0;
      out_b = mod_on;
      out_c = 1'b1;
      out_d = 1'b0;
    end
  end
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_full,
  input logic [DW-1:0] dead_cnt,
  input logic          pwm_in,
  input logic          out_a,
  input logic          out_b,
  input logic          out_c,
  input logic          out_d
);
  AST_HALF_CD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_full |-> (!out_c && !out_d)); // R1

  AST_HALF_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_full |-> !(out_a && out_b)); // R2

  AST_DEAD_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_full && dead_cnt != '0 && $rose(out_a)) |-> $past(pwm_in)); // R2

  AST_FALL_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_full && !pwm_in) |-> !out_a); // R3

  AST_FULL_LEG_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_full |-> (!(out_a && out_b) && !(out_c && out_d))); // R4

  AST_REV_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_full && $past(mode_full) && $rose(out_c)) |-> !out_b); // R7

  AST_FWD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_full && $past(mode_full) && $rose(out_a)) |-> !out_d); // R7
endmodule

bind bridge_steer bs_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_full (mode_full),
  .dead_cnt  (dead_cnt),
  .pwm_in    (pwm_in),
  .out_a     (out_a),
  .out_b     (out_b),
  .out_c     (out_c),
  .out_d     (out_d)
);

// File: tb/sim_bridge_steer.sv
module sim_bridge_steer;
  localparam int PER = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_full = 1'b1;
  logic       dir_rev = 1'b0;
  logic [7:0] dead_cnt = '0;
  logic [1:0] psc_sel = '0;
  logic       pwm_in = 1'b0;
  logic [7:0] end_cnt = 8'd5;
  logic       out_a, out_b, out_c, out_d;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bridge_steer u0 (
    .clk(clk), .rst_n(rst_n), .mode_full(mode_full), .dir_rev(dir_rev),
    .dead_cnt(dead_cnt), .psc_sel(psc_sel), .pwm_in(pwm_in), .end_cnt(end_cnt),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  task automatic check4(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {out_a, out_b, out_c, out_d};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t abcd actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // half-bridge: one cycle high to settle, then low lo, high hi, low lo
  task automatic run_half(input int d, input int hi, input int lo);
    int t;
    logic p;
    t = 4 * d;
    mode_full = 1'b0;
    dead_cnt = 8'(d);
    @(negedge clk); pwm_in = 1'b1;
    for (int s = 0; s < 3; s++) begin
      int len;
      p = (s == 1);
      len = (s == 1) ? hi : lo;
      for (int i = 0; i < len; i++) begin
        logic ea, eb;
        @(negedge clk);
        pwm_in = p;
        #2;
        ea = p && (i >= t);
        eb = !p && (i >= t);
        if (len <= t) check4("R3 cancelled request", {ea, eb, 2'b00});
        else if (i == 0) check4("R3 immediate off", {ea, eb, 2'b00});
        else check4("R1/R2 half-bridge deadband", {ea, eb, 2'b00});
      end
    end
  endtask

  // full-bridge: two periods, direction request changes at start of first
  task automatic run_full(input logic [1:0] psc, input logic nd, input bit revert);
    int lead;
    logic od;
    lead = (psc == 2'b00) ? 1 : (psc == 2'b01) ? 4 : 16;
    od = !nd;
    mode_full = 1'b1;
    psc_sel = psc;
    for (int k = 0; k < 2 * PER; k++) begin
      int pos, e;
      logic ad, bl, p;
      string tag;
      pos = k % PER;
      e = PER - 1 - pos;
      p = (pos % 7) != 0;
      @(negedge clk);
      end_cnt = 8'(e);
      pwm_in = p;
      if (k == 0) dir_rev = nd;
      if (revert && k == 3) dir_rev = od;
      #2;
      bl = 1'b0;
      if (revert) begin
        ad = od; tag = "R8 undone change";
      end else if (k < PER && e < lead) begin
        ad = nd; bl = 1'b1; tag = "R6/R7 early switch window";
      end else if (k < PER) begin
        ad = od; tag = "R5 old direction kept";
      end else begin
        ad = nd; tag = "R4 new direction";
      end
      if (!ad) check4(tag, {1'b1, 1'b0, 1'b0, p && !bl});
      else check4(tag, {1'b0, p && !bl, 1'b1, 1'b0});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check4("R9 reset forward", 4'b1000);
    @(negedge clk); pwm_in = 1'b1; #2;
    check4("R9/R4 forward after reset", 4'b1001);

    for (int d = 0; d < 4; d++) begin
      run_half(d, 1, 3);
      run_half(d, 3, 5);
      run_half(d, 6, 8);
      run_half(d, 13, 15);
    end

    @(negedge clk);
    mode_full = 1'b1;
    dir_rev = 1'b0;
    end_cnt = 8'd39;
    @(negedge clk);
    for (int ps = 0; ps < 4; ps++) begin
      run_full(2'(ps), 1'b1, 1'b0);
      run_full(2'(ps), 1'b0, 1'b0);
      run_full(2'(ps), 1'b1, 1'b1);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule